// File: doc/BRIEF.md
# Serial Configuration Register Bank with Strap-Selected Defaults

This block is the slave end of a four-wire serial link: an active-low select, a serial clock, a data input and a data output. It holds the configuration bytes of a radio front-end. These bytes cover the synthesizer divider ratios, the output-clock source and buffer enables, the drive-edge speed, the per-stage power enables, the charge-pump current and the loop-filter setting. A host reaches each byte with a sixteen-clock frame. The frame carries an address byte and then a data byte. Bit 7 of the address picks the direction: clear for a write, set for a read.

The serial pins are brought into the core clock domain through synchronizer chains, and edges are detected there. A strap input chooses one of two default sets, which the synchronous reset loads. The two divider values go out on a single 24-bit bus. The two feedback-ratio bytes are held in staging registers and reach the bus only when the reference-ratio byte is written, so the synthesizer never sees a half-updated pair.

Top module: `cfg_spi_regfile`

## Requirements
- R1: A frame is the span during which `spi_sel_n` is low. The block samples `spi_mosi` on rising `spi_sck` edges (clock idles low). The first 8 bits form the address and the next 8 bits form the data, each sent most significant bit first.
- R2: An address byte with bit 7 clear writes the data byte into the register at that address. The same register read with bit 7 set returns the stored value. Register addresses are 0x40, 0x41, 0x42, 0x43, 0x50, 0x51, 0x52 and 0x60, and their read codes are 0xC0–0xC3, 0xD0–0xD2 and 0xE0.
- R3: In a read frame, bit 7 of the data is on `spi_miso` before the ninth rising clock edge. Each later falling edge moves the next lower bit onto the line. Outside read data, `spi_miso` is low.
- R4: With `strap_hi` low during reset, the feedback ratio N is 96 and the reference ratio R is 1. Register 0x43 then reads 0x0A: clock source 0 and crystal-buffer enable 0.
- R5: With `strap_hi` high during reset, N is 1555 and R is 19. Register 0x43 then reads 0x0F: clock source 1 and crystal-buffer enable 1.
- R6: Some reset values do not depend on the strap. Register 0x50 is 0x00, 0x51 is 0xBF (every stage enable set), 0x52 is 0x1B (pump code 2'b11, filter code 3'b110) and 0x60 is 0x00.
- R7: Several outputs copy register fields. `clk_cfg` is bits [3:0] of 0x43: source select in bit 0, slow edges in bit 1, crystal buffer in bit 2, clock buffer in bit 3. `ifbuf_en` is bit 0 of 0x50. `blk_en` is 0x51. `trim` is bits [4:0] of 0x52, with the pump code in [1:0] and the filter code in [4:2]. `rf_force` is bit 0 of 0x60.
- R8: N[11:8] sits in bits [3:0] of 0x40, N[7:0] is 0x41, and R is bits [5:0] of 0x42. `div_bus` is {4'b0, N, 2'b0, R}. It changes only in the cycle after a write to 0x42, and then takes the staged N and the new R.
- R9: Reserved bits read as zero and ignore writes. The writable masks are: 0x40 0x0F, 0x41 0xFF, 0x42 0x3F, 0x43 0x0F, 0x50 0x01, 0x51 0xBF, 0x52 0x1F, 0x60 0x01.
- R10: A write to an unmapped address changes nothing, and a read of an unmapped address returns 0x00.
- R11: A frame in which select rises before the sixteenth rising clock edge writes nothing.
- R12: The synchronous reset `rst` reloads the full default set chosen by `strap_hi`, discarding earlier writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_hi | input | 1 | Selects which default set reset loads |
| spi_sel_n | input | 1 | Serial select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial read data out of the block |
| div_bus | output | 24 | Committed divider ratios {4'b0, N, 2'b0, R} |
| clk_cfg | output | 4 | Clock source, slow edge, crystal buffer and clock buffer controls |
| ifbuf_en | output | 1 | IF test buffer enable |
| blk_en | output | 8 | Stage power enables (bit 6 always 0) |
| trim | output | 5 | Filter code [4:2] and pump current code [1:0] |
| rf_force | output | 1 | Forces the receive chain on |

## Verification
The hardest case to reach from the ports is a divider bus that stays wrong for a while. Staged N bytes must be readable and yet stay invisible on `div_bus` until R is written. The stimulus writes new bytes to 0x40 and 0x41, reads them back while checking that the bus keeps the old ratios, and only then writes 0x42. Frames cut short after 12 and after 15 clocks show that an almost complete frame leaves no trace. A sweep of byte patterns over every register, followed by reads through the read codes, checks each writable mask and each field tap.

// File: rtl/cfgspi_pkg.sv
package cfgspi_pkg;

    localparam int NREG   = 8;
    localparam int IDXW   = $clog2(NREG);
    localparam int DIVW   = 24;

    typedef logic [7:0]      byte_t;
    typedef logic [IDXW-1:0] idx_t;

    typedef struct packed {
        logic hit;
        idx_t idx;
    } decode_t;

    localparam idx_t IDX_NHI  = 3'd0;
    localparam idx_t IDX_NLO  = 3'd1;
    localparam idx_t IDX_RDIV = 3'd2;
    localparam idx_t IDX_CLK  = 3'd3;
    localparam idx_t IDX_TST  = 3'd4;
    localparam idx_t IDX_BLK  = 3'd5;
    localparam idx_t IDX_TRIM = 3'd6;
    localparam idx_t IDX_RFC  = 3'd7;

    function automatic decode_t decode(input logic [6:0] a);
        decode_t d;
        d.hit = 1'b1;
        case (a)
            7'h40:   d.idx = IDX_NHI;
            7'h41:   d.idx = IDX_NLO;
            7'h42:   d.idx = IDX_RDIV;
            7'h43:   d.idx = IDX_CLK;
            7'h50:   d.idx = IDX_TST;
            7'h51:   d.idx = IDX_BLK;
            7'h52:   d.idx = IDX_TRIM;
            7'h60:   d.idx = IDX_RFC;
            default: begin d.hit = 1'b0; d.idx = '0; end
        endcase
        return d;
    endfunction

    function automatic byte_t wmask(input idx_t i);
        case (i)
            IDX_NHI:  return 8'h0F;
            IDX_NLO:  return 8'hFF;
            IDX_RDIV: return 8'h3F;
            IDX_CLK:  return 8'h0F;
            IDX_TST:  return 8'h01;
            IDX_BLK:  return 8'hBF;
            IDX_TRIM: return 8'h1F;
            default:  return 8'h01;
        endcase
    endfunction

    function automatic byte_t dflt(input idx_t i, input logic strap);
        case (i)
            IDX_NHI:  return strap ? 8'h06 : 8'h00;
            IDX_NLO:  return strap ? 8'h13 : 8'h60;
            IDX_RDIV: return strap ? 8'h13 : 8'h01;
            IDX_CLK:  return strap ? 8'h0F : 8'h0A;
            IDX_TST:  return 8'h00;
            IDX_BLK:  return 8'hBF;
            IDX_TRIM: return 8'h1B;
            default:  return 8'h00;
        endcase
    endfunction

    function automatic logic [DIVW-1:0] pack_div(input byte_t hi, input byte_t lo, input byte_t r);
        return {4'b0, hi[3:0], lo, 2'b0, r[5:0]};
    endfunction

endpackage

// File: rtl/spi_frame.sv
module spi_frame
    import cfgspi_pkg::*;
#(
    parameter int SYNC  = 2,
    parameter int FRAME = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sel_n,
    input  logic       sck,
    input  logic       mosi,
    output logic       miso,
    output logic [6:0] look_addr,
    input  byte_t      look_data,
    output logic       wr_stb,
    output logic [6:0] wr_addr,
    output byte_t      wr_data
);
    localparam int HALF = FRAME / 2;
    localparam int CW   = $clog2(FRAME + 1);

    logic [SYNC-1:0] sck_p, sel_p, mosi_p;
    logic            sck_d;
    logic [CW-1:0]   cnt;
    byte_t           shift, tx, addr_q;

    wire sck_s  = sck_p[SYNC-1];
    wire sel_s  = sel_p[SYNC-1];
    wire mosi_s = mosi_p[SYNC-1];
    wire rise   = sck_s & ~sck_d;
    wire fall   = ~sck_s & sck_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_p  <= '0;
            sel_p  <= '1;
            mosi_p <= '0;
        end else begin
            sck_p  <= {sck_p[SYNC-2:0], sck};
            sel_p  <= {sel_p[SYNC-2:0], sel_n};
            mosi_p <= {mosi_p[SYNC-2:0], mosi};
        end
    end

    assign look_addr = {shift[5:0], mosi_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d   <= 1'b0;
            cnt     <= '0;
            shift   <= '0;
            tx      <= '0;
            addr_q  <= '0;
            wr_stb  <= 1'b0;
            wr_data <= '0;
        end else begin
            sck_d  <= sck_s;
            wr_stb <= 1'b0;
            if (sel_s) begin
                cnt <= '0;
                tx  <= '0;
            end else begin
                if (rise && cnt != CW'(FRAME)) begin
                    shift <= {shift[6:0], mosi_s};
                    cnt   <= cnt + 1'b1;
                    if (cnt == CW'(HALF - 1)) begin
                        addr_q <= {shift[6:0], mosi_s};
                        tx     <= shift[6] ? look_data : 8'h00;
                    end
                    if (cnt == CW'(FRAME - 1) && !addr_q[7]) begin
                        wr_stb  <= 1'b1;
                        wr_data <= {shift[6:0], mosi_s};
                    end
                end
                if (fall && cnt > CW'(HALF) && cnt < CW'(FRAME))
                    tx <= {tx[6:0], 1'b0};
            end
        end
    end

    assign miso    = tx[7];
    assign wr_addr = addr_q[6:0];

    AST_MISO_IDLE:  assert property (@(posedge clk) disable iff (rst) sel_s |=> !miso);       // R3
    AST_WR_SELECT:  assert property (@(posedge clk) disable iff (rst) wr_stb |-> $past(!sel_s)); // R11
    AST_WR_SINGLE:  assert property (@(posedge clk) disable iff (rst) wr_stb |=> !wr_stb);    // R1
    AST_WR_DIR:     assert property (@(posedge clk) disable iff (rst) wr_stb |-> !addr_q[7]); // R2

endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
    import cfgspi_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   strap,
    input  logic                   wr_stb,
    input  logic [6:0]             wr_addr,
    input  byte_t                  wr_data,
    input  logic [6:0]             rd_addr,
    output byte_t                  rd_data,
    output byte_t [NREG-1:0]       regs_o,
    output logic [DIVW-1:0]        div_bus
);
    decode_t wdec, rdec;
    assign wdec = decode(wr_addr);
    assign rdec = decode(rd_addr);

    wire commit = wr_stb && wdec.hit && wdec.idx == IDX_RDIV;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs_o[i] <= dflt(idx_t'(i), strap);
            else if (wr_stb && wdec.hit && wdec.idx == idx_t'(i))
                regs_o[i] <= wr_data & wmask(idx_t'(i));
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            div_bus <= pack_div(dflt(IDX_NHI, strap), dflt(IDX_NLO, strap), dflt(IDX_RDIV, strap));
        else if (commit)
            div_bus <= pack_div(regs_o[IDX_NHI], regs_o[IDX_NLO], wr_data);
    end

    assign rd_data = rdec.hit ? regs_o[rdec.idx] : 8'h00;

    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (rst) !commit |=> $stable(div_bus)); // R8
    AST_RST_LOAD: assert property (@(posedge clk) disable iff (rst) $past(rst) |->
        div_bus == pack_div(dflt(IDX_NHI, $past(strap)), dflt(IDX_NLO, $past(strap)),
                            dflt(IDX_RDIV, $past(strap))));                                     // R12

endmodule

// File: rtl/cfg_spi_regfile.sv
module cfg_spi_regfile
    import cfgspi_pkg::*;
#(
    parameter int SYNC = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        strap_hi,
    input  logic        spi_sel_n,
    input  logic        spi_sck,
    input  logic        spi_mosi,
    output logic        spi_miso,
    output logic [23:0] div_bus,
    output logic [3:0]  clk_cfg,
    output logic        ifbuf_en,
    output logic [7:0]  blk_en,
    output logic [4:0]  trim,
    output logic        rf_force
);
    logic [6:0]       look_addr, wr_addr;
    byte_t            look_data, wr_data;
    logic             wr_stb;
    byte_t [NREG-1:0] regs;

    spi_frame #(.SYNC(SYNC), .FRAME(16)) u_frame (
        .clk       (clk),
        .rst       (rst),
        .sel_n     (spi_sel_n),
        .sck       (spi_sck),
        .mosi      (spi_mosi),
        .miso      (spi_miso),
        .look_addr (look_addr),
        .look_data (look_data),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    cfg_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .strap   (strap_hi),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (look_addr),
        .rd_data (look_data),
        .regs_o  (regs),
        .div_bus (div_bus)
    );

    assign clk_cfg  = regs[IDX_CLK][3:0];
    assign ifbuf_en = regs[IDX_TST][0];
    assign blk_en   = regs[IDX_BLK];
    assign trim     = regs[IDX_TRIM][4:0];
    assign rf_force = regs[IDX_RFC][0];

endmodule

// File: tb/sim_cfg_spi_regfile.sv
`timescale 1ns/1ps
module sim_cfg_spi_regfile;

    localparam int HALF = 4;

    logic clk = 0, rst = 1, strap_hi = 0;
    logic sel_n = 1, sck = 0, mosi = 0;
    logic miso, ifbuf_en, rf_force;
    logic [23:0] div_bus;
    logic [3:0]  clk_cfg;
    logic [7:0]  blk_en;
    logic [4:0]  trim;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    logic [7:0] exp_r [8];
    logic [23:0] exp_div;
    logic [7:0] addr_of [8] = '{8'h40, 8'h41, 8'h42, 8'h43, 8'h50, 8'h51, 8'h52, 8'h60};

    always #4 clk = ~clk;

    cfg_spi_regfile u0 (
        .clk(clk), .rst(rst), .strap_hi(strap_hi), .spi_sel_n(sel_n), .spi_sck(sck),
        .spi_mosi(mosi), .spi_miso(miso), .div_bus(div_bus), .clk_cfg(clk_cfg),
        .ifbuf_en(ifbuf_en), .blk_en(blk_en), .trim(trim), .rf_force(rf_force)
    );

    function automatic int idx_of(input logic [6:0] a);
        for (int i = 0; i < 8; i++) if (addr_of[i][6:0] == a) return i;
        return -1;
    endfunction

    function automatic logic [7:0] mask_of(input int i);
        logic [7:0] m [8] = '{8'h0F, 8'hFF, 8'h3F, 8'h0F, 8'h01, 8'hBF, 8'h1F, 8'h01};
        return m[i];
    endfunction

    function automatic logic [23:0] div_of(input logic [7:0] hi, lo, r);
        int n = hi[3:0] * 256 + lo;
        return 24'(n) * 24'd256 + 24'(r[5:0]);
    endfunction

    task automatic load_defaults(input logic s);
        exp_r[0] = s ? 8'h06 : 8'h00;   // N = 1555 or 96
        exp_r[1] = s ? 8'h13 : 8'h60;
        exp_r[2] = s ? 8'd19 : 8'd1;
        exp_r[3] = s ? 8'h0F : 8'h0A;
        exp_r[4] = 8'h00; exp_r[5] = 8'hBF; exp_r[6] = 8'h1B; exp_r[7] = 8'h00;
        exp_div  = div_of(exp_r[0], exp_r[1], exp_r[2]);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] a, input logic [7:0] d, input int nclk, output logic [7:0] rd);
        logic [15:0] w;
        w = {a, d};
        rd = 8'h00;
        wait_cyc(1);
        sel_n = 0;
        wait_cyc(HALF);
        for (int i = 0; i < nclk; i++) begin
            mosi = w[15-i];
            wait_cyc(HALF);
            if (i >= 8) rd[15-i] = miso;
            sck = 1;
            wait_cyc(HALF);
            sck = 0;
        end
        wait_cyc(HALF);
        sel_n = 1;
        mosi = 0;
        wait_cyc(8);
    endtask

    task automatic chk_outs(input string tag);
        chk({tag, " R8 div_bus"}, 32'(div_bus), 32'(exp_div));
        chk({tag, " R7 clk_cfg"}, 32'(clk_cfg), 32'(exp_r[3][3:0]));
        chk({tag, " R7 ifbuf_en"}, 32'(ifbuf_en), 32'(exp_r[4][0]));
        chk({tag, " R7 blk_en"}, 32'(blk_en), 32'(exp_r[5]));
        chk({tag, " R7 trim"}, 32'(trim), 32'(exp_r[6][4:0]));
        chk({tag, " R7 rf_force"}, 32'(rf_force), 32'(exp_r[7][0]));
    endtask

    task automatic chk_reads(input string tag);
        logic [7:0] rd;
        for (int i = 0; i < 8; i++) begin
            xfer(addr_of[i] | 8'h80, 8'h00, 16, rd);
            chk({tag, " R2 R3 readback"}, 32'(rd), 32'(exp_r[i]));
        end
    endtask

    task automatic wr(input int i, input logic [7:0] d);
        logic [7:0] rd;
        xfer(addr_of[i], d, 16, rd);
        exp_r[i] = d & mask_of(i);
        if (i == 2) exp_div = div_of(exp_r[0], exp_r[1], exp_r[2]);
    endtask

    task automatic do_reset(input logic s);
        wait_cyc(1);
        strap_hi = s; rst = 1;
        wait_cyc(4);
        rst = 0;
        wait_cyc(2);
        load_defaults(s);
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    initial begin
        logic [7:0] rd;
        logic [7:0] pat;
        logic [23:0] div_before;

        // R4 R6: strap low defaults
        do_reset(1'b0);
        chk("R3 idle miso", 32'(miso), 0);
        chk_outs("R4 R6 reset");
        chk_reads("R4 R6 reset");

        // R5: strap high defaults
        do_reset(1'b1);
        chk_outs("R5 reset");
        chk_reads("R5 reset");

        // R1 R2 R7 R9: pattern sweep over every register
        for (int i = 0; i < 8; i++) begin
            for (int k = 0; k < 24; k++) begin
                pat = (k < 16) ? 8'(k * 17) : 8'(1 << (k - 16));
                wr(i, pat);
                chk_outs("R7 R9 sweep");
                xfer(addr_of[i] | 8'h80, 8'h00, 16, rd);
                chk("R9 masked readback", 32'(rd), 32'(pat & mask_of(i)));
            end
        end

        // R8: staged N bytes stay off the bus until R is written
        div_before = exp_div;
        wr(0, 8'h0B); wr(1, 8'hC4);
        chk("R8 staged hold", 32'(div_bus), 32'(div_before));
        xfer(8'hC1, 8'h00, 16, rd);
        chk("R8 staged readable", 32'(rd), 32'h00C4);
        wr(2, 8'h2A);
        chk("R8 commit", 32'(div_bus), 32'(div_of(8'h0B, 8'hC4, 8'h2A)));

        // R10: unmapped writes and reads
        begin
            logic [7:0] um [8] = '{8'h00, 8'h3F, 8'h44, 8'h4F, 8'h53, 8'h5F, 8'h61, 8'h7F};
            for (int j = 0; j < 8; j++) xfer(um[j], 8'hFF, 16, rd);
            chk_outs("R10 unmapped write");
            chk_reads("R10 unmapped write");
            for (int a = 0; a < 128; a++) begin
                xfer(8'(a) | 8'h80, 8'h00, 16, rd);
                if (idx_of(7'(a)) < 0) chk("R10 unmapped read", 32'(rd), 0);
                else chk("R2 read sweep", 32'(rd), 32'(exp_r[idx_of(7'(a))]));
            end
        end

        // R11: aborted frames
        xfer(8'h60, 8'h01, 15, rd);
        chk("R11 abort 15", 32'(rf_force), 32'(exp_r[7][0]));
        xfer(8'h51, 8'h00, 12, rd);
        chk("R11 abort 12", 32'(blk_en), 32'(exp_r[5]));
        wr(7, 8'h01);
        chk("R11 full frame after abort", 32'(rf_force), 1);

        // R12: reset discards writes
        do_reset(1'b0);
        chk_outs("R12 reload");
        chk_reads("R12 reload");

        finish_run();
    end

endmodule